// File: doc/BRIEF.md
# Fast Interrupt Return Sequencer

This block carries out a reduced, privileged return from an interrupt. When started, it reads a five-word return frame from a simple memory read port, beginning at the current stack pointer. From those words it produces a new instruction pointer, code selector, stack selector, stack pointer, flags word and privilege level. All of them are committed together in one cycle.

It never reads segment descriptors. The code and stack segments it restores are taken to be flat: base 0, a 4 GiB limit, code readable and executable, stack readable and writable. None of this is checked. The target privilege is the low two bits of the popped code selector, so a return to level 0 or level 3 takes the same path. The flags it restores are cleaned up:
- no task return is ever started;
- virtual-8086 mode is never entered;
- the trace, direction, alignment-check, resume and I/O-privilege fields are cleared;
- interrupts are enabled.

A mode input chooses between a 64-bit and a 32-bit target. The sequencer refuses to run unless the current privilege level is 0. In 64-bit mode it also refuses a non-canonical instruction pointer. In both cases it raises a fault and commits nothing.

Top module: `fast_iret_seq`

## Requirements
- R1: While reset is held and in the first cycle after it, `done`, `fault` and `mem_req` are 0 and every result output (`new_ip`, `new_cs`, `new_ss`, `new_sp`, `new_flags`, `new_cpl`, `frame_top`) is 0.
- R2: A start with `cur_cpl` not equal to 0 raises `fault` for one cycle, in the cycle after the start. It issues no memory read and leaves every result output unchanged.
- R3: The frame words are read in this order: instruction pointer, code selector, flags, stack pointer, stack selector. Word k is read from address `cur_sp + k*S`, where S is 8 in 64-bit mode (`mode64`=1) and 4 in 32-bit mode. One word is taken per cycle in which `mem_ack` is high.
- R4: `new_cpl` equals bits [1:0] of the popped code selector. `new_cs` and `new_ss` are bits [15:0] of their frame words. Levels 0 and 3 are both accepted.
- R5: `new_flags` is the popped flags word with these changes: bits 8 (trace), 10 (direction), 12 and 13 (I/O privilege), 14 (nested task), 16 (resume), 17 (virtual-8086) and 18 (alignment check) are forced to 0, and bit 9 (interrupt enable) is forced to 1. All other bits pass through unchanged.
- R6: In 32-bit mode only bits [31:0] of each read word are used. `new_ip`, `new_sp` and `new_flags` are zero-extended to 64 bits.
- R7: In 64-bit mode a popped instruction pointer whose bits [63:47] are not all equal raises `fault` for one cycle instead of `done`. No result output changes.
- R8: On success, `done` is high for exactly one cycle. All result outputs take their new values in that same cycle. `frame_top` (the stack pointer advanced past the frame, `cur_sp + 5*S`) changes only then.
- R9: A `start` that arrives while an operation is in progress is ignored. The running operation keeps its captured stack pointer and mode, and it produces a single completion.
- R10: `done` and `fault` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a return; sampled while idle |
| mode64 | input | 1 | 1 selects a 64-bit target, 0 a 32-bit target |
| cur_cpl | input | 2 | Current privilege level |
| cur_sp | input | 64 | Current stack pointer, where the frame starts |
| mem_req | output | 1 | Read request |
| mem_addr | output | 64 | Read address |
| mem_ack | input | 1 | Read data valid; one word is accepted per high cycle |
| mem_rdata | input | 64 | Read data |
| done | output | 1 | One-cycle strobe: results committed |
| fault | output | 1 | One-cycle strobe: operation refused, nothing committed |
| new_ip | output | 64 | Restored instruction pointer |
| new_cs | output | 16 | Restored code selector |
| new_ss | output | 16 | Restored stack selector |
| new_sp | output | 64 | Restored stack pointer |
| new_flags | output | 64 | Restored, cleaned flags |
| new_cpl | output | 2 | New privilege level |
| frame_top | output | 64 | Stack pointer advanced past the frame |

## Verification
The bench drives the main path with several kinds of frame:
- A 64-bit return to level 3 with an all-ones flags word separates the forced bits from the passed bits, and it uses back-to-back acknowledges.
- A 64-bit return to level 0 with an all-zero flags word and a two-cycle gap between acknowledges shows that interrupt enable is set and that waiting on memory changes nothing. Its pointer sits exactly on the lower canonical boundary.
- A 32-bit return with garbage in the upper halves of every word separates zero extension from pass-through and checks the 4-byte stride.
- Two non-canonical pointers, one on each side of the canonical hole, a start at privilege 3, and a second start pulsed mid-frame show that refused and ignored requests leave the committed state untouched.

// File: rtl/fis_pkg.sv
// Package: shared constants and state encoding for the fast interrupt return
// sequencer. Assumes a flags word of at least 19 bits.
package fis_pkg;

    // Number of words in a return frame and the position of each.
    localparam int NWORDS  = 5;
    localparam int W_IP    = 0;
    localparam int W_CS    = 1;
    localparam int W_FLAGS = 2;
    localparam int W_SP    = 3;
    localparam int W_SS    = 4;

    // Bit positions in the flags word that the sequencer overrides.
    localparam int FB_TRACE = 8;
    localparam int FB_IEN   = 9;
    localparam int FB_DIR   = 10;
    localparam int FB_IOPL0 = 12;
    localparam int FB_IOPL1 = 13;
    localparam int FB_NEST  = 14;
    localparam int FB_RES   = 16;
    localparam int FB_V86   = 17;
    localparam int FB_ALIGN = 18;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_READ  = 2'd1,
        ST_CHECK = 2'd2
    } seq_state_t;

endpackage

// File: rtl/fis_addr_gen.sv
// Module: fis_addr_gen
// Computes the read address of frame word idx and the stack pointer just past
// the frame. Slot size is DW/8 bytes in 64-bit mode and 4 bytes otherwise.
// Purely combinational.
module fis_addr_gen #(
    parameter int AW     = 64,
    parameter int DW     = 64,
    parameter int NW     = 5,
    parameter int IDX_W  = 3
) (
    input  logic [AW-1:0]    base,
    input  logic             wide,
    input  logic [IDX_W-1:0] idx,
    output logic [AW-1:0]    addr,
    output logic [AW-1:0]    frame_end
);
    localparam int SH_WIDE   = $clog2(DW / 8);
    localparam int SH_NARROW = 2;

    logic [AW-1:0] idx_ext;
    logic [AW-1:0] nw_ext;

    // Offset of the selected word and the whole-frame size, scaled by slot.
    always_comb begin
        idx_ext   = {{(AW-IDX_W){1'b0}}, idx};
        nw_ext    = AW'(NW);
        addr      = base + (wide ? (idx_ext << SH_WIDE) : (idx_ext << SH_NARROW));
        frame_end = base + (wide ? (nw_ext << SH_WIDE) : (nw_ext << SH_NARROW));
    end
endmodule

// File: rtl/fis_flag_fix.sv
// Module: fis_flag_fix
// Cleans a popped flags word: clears trace, direction, I/O privilege, nested
// task, resume, virtual-8086 and alignment-check; sets interrupt enable.
// Other bits pass through. Assumes DW >= 19.
module fis_flag_fix #(
    parameter int DW = 64
) (
    input  logic [DW-1:0] raw,
    output logic [DW-1:0] fixed
);
    import fis_pkg::*;

    // Apply the fixed overrides to the popped value.
    always_comb begin
        fixed           = raw;
        fixed[FB_TRACE] = 1'b0;
        fixed[FB_DIR]   = 1'b0;
        fixed[FB_IOPL0] = 1'b0;
        fixed[FB_IOPL1] = 1'b0;
        fixed[FB_NEST]  = 1'b0;
        fixed[FB_RES]   = 1'b0;
        fixed[FB_V86]   = 1'b0;
        fixed[FB_ALIGN] = 1'b0;
        fixed[FB_IEN]   = 1'b1;
    end
endmodule

// File: rtl/fis_canon.sv
// Module: fis_canon
// Flags whether an address is canonical for a VA_BITS-bit virtual space:
// every bit from VA_BITS-1 up to the top must be equal.
module fis_canon #(
    parameter int DW      = 64,
    parameter int VA_BITS = 48
) (
    input  logic [DW-1:0] ip,
    output logic          ok
);
    logic [DW-VA_BITS:0] upper;

    // All-zero or all-one upper slice means canonical.
    always_comb begin
        upper = ip[DW-1:VA_BITS-1];
        ok    = (&upper) | ~(|upper);
    end
endmodule

// File: rtl/fast_iret_seq.sv
// Module: fast_iret_seq
// Fast privileged return-from-interrupt sequencer. On start at privilege 0 it
// reads five frame words (ip, cs, flags, sp, ss) from cur_sp upward, one per
// mem_ack. It then checks the pointer's canonical form (64-bit mode only) and
// either commits all results with a done pulse or raises fault and commits
// nothing. No descriptors are read; segments are assumed flat.
// Assumes mem_ack is only high while mem_req is high.
module fast_iret_seq #(
    parameter int AW      = 64,
    parameter int DW      = 64,
    parameter int SELW    = 16,
    parameter int VA_BITS = 48
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            mode64,
    input  logic [1:0]      cur_cpl,
    input  logic [AW-1:0]   cur_sp,
    output logic            mem_req,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_ack,
    input  logic [DW-1:0]   mem_rdata,
    output logic            done,
    output logic            fault,
    output logic [DW-1:0]   new_ip,
    output logic [SELW-1:0] new_cs,
    output logic [SELW-1:0] new_ss,
    output logic [DW-1:0]   new_sp,
    output logic [DW-1:0]   new_flags,
    output logic [1:0]      new_cpl,
    output logic [AW-1:0]   frame_top
);
    import fis_pkg::*;

    localparam int IDX_W = $clog2(NWORDS);
    localparam int HALF  = 32;

    seq_state_t        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [AW-1:0]     base_q;
    logic              wide_q;
    logic [DW-1:0]     word_q [NWORDS];
    logic [DW-1:0]     rdata_ext;
    logic [DW-1:0]     flags_fixed;
    logic [AW-1:0]     frame_end;
    logic              ip_ok;
    logic              busy;
    logic              last_word;

    assign busy      = (state_q != ST_IDLE);
    assign mem_req   = (state_q == ST_READ);
    assign last_word = (idx_q == IDX_W'(NWORDS - 1));

    // Narrow mode uses only the low half of each word, zero-extended.
    always_comb begin
        rdata_ext = wide_q ? mem_rdata : {{(DW-HALF){1'b0}}, mem_rdata[HALF-1:0]};
    end

    fis_addr_gen #(.AW(AW), .DW(DW), .NW(NWORDS), .IDX_W(IDX_W)) u_addr (
        .base      (base_q),
        .wide      (wide_q),
        .idx       (idx_q),
        .addr      (mem_addr),
        .frame_end (frame_end)
    );

    fis_flag_fix #(.DW(DW)) u_flags (
        .raw   (word_q[W_FLAGS]),
        .fixed (flags_fixed)
    );

    fis_canon #(.DW(DW), .VA_BITS(VA_BITS)) u_canon (
        .ip (word_q[W_IP]),
        .ok (ip_ok)
    );

    // One capture register per frame slot, loaded when its read completes.
    for (genvar k = 0; k < NWORDS; k++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[k] <= '0;
            else if (mem_req && mem_ack && idx_q == IDX_W'(k))
                word_q[k] <= rdata_ext;
        end
    end

    // Sequencer: accept start, walk the frame, then check and commit or fault.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            idx_q     <= '0;
            base_q    <= '0;
            wide_q    <= 1'b0;
            done      <= 1'b0;
            fault     <= 1'b0;
            new_ip    <= '0;
            new_cs    <= '0;
            new_ss    <= '0;
            new_sp    <= '0;
            new_flags <= '0;
            new_cpl   <= '0;
            frame_top <= '0;
        end else begin
            done  <= 1'b0;
            fault <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        if (cur_cpl != 2'd0) begin
                            fault <= 1'b1;
                        end else begin
                            base_q  <= cur_sp;
                            wide_q  <= mode64;
                            idx_q   <= '0;
                            state_q <= ST_READ;
                        end
                    end
                end
                ST_READ: begin
                    if (mem_ack) begin
                        if (last_word) state_q <= ST_CHECK;
                        else           idx_q   <= idx_q + 1'b1;
                    end
                end
                ST_CHECK: begin
                    state_q <= ST_IDLE;
                    if (wide_q && !ip_ok) begin
                        fault <= 1'b1;
                    end else begin
                        done      <= 1'b1;
                        new_ip    <= word_q[W_IP];
                        new_cs    <= word_q[W_CS][SELW-1:0];
                        new_ss    <= word_q[W_SS][SELW-1:0];
                        new_sp    <= word_q[W_SP];
                        new_flags <= flags_fixed;
                        new_cpl   <= word_q[W_CS][1:0];
                        frame_top <= frame_end;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/fis_checker.sv
// Module: fis_checker
// Property checks for fast_iret_seq, attached with bind below.
module fis_checker #(
    parameter int AW   = 64,
    parameter int DW   = 64,
    parameter int SELW = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            start,
    input logic            busy,
    input logic [1:0]      cur_cpl,
    input logic            mem_req,
    input logic            done,
    input logic            fault,
    input logic [DW-1:0]   new_ip,
    input logic [SELW-1:0] new_cs,
    input logic [DW-1:0]   new_flags,
    input logic [1:0]      new_cpl,
    input logic [AW-1:0]   frame_top
);
    // R2: a start at nonzero privilege is refused in the next cycle.
    p_priv_fault_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && cur_cpl != 2'd0) |=> (fault && !mem_req));

    // R4: new privilege matches the selector's low bits on commit.
    p_cpl_from_cs_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_cpl == new_cs[1:0]));

    // R5: forced flag values on commit.
    p_flags_forced_r5: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (new_flags[9] && !new_flags[8] && !new_flags[10] && !new_flags[12]
                  && !new_flags[13] && !new_flags[14] && !new_flags[16]
                  && !new_flags[17] && !new_flags[18]));

    // R7: a committed pointer is always canonical.
    p_canon_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((&new_ip[DW-1:47]) || !(|new_ip[DW-1:47])));

    // R7: a fault leaves the committed results untouched.
    p_fault_no_commit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> ($stable(new_ip) && $stable(frame_top) && $stable(new_flags)));

    // R8: done is a single-cycle strobe.
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: frame_top moves only with done.
    p_top_on_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(frame_top));

    // R10: done and fault are exclusive.
    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && fault));
endmodule

bind fast_iret_seq fis_checker #(.AW(AW), .DW(DW), .SELW(SELW)) u_fis_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .cur_cpl   (cur_cpl),
    .mem_req   (mem_req),
    .done      (done),
    .fault     (fault),
    .new_ip    (new_ip),
    .new_cs    (new_cs),
    .new_flags (new_flags),
    .new_cpl   (new_cpl),
    .frame_top (frame_top)
);

// File: tb/tb_fast_iret_seq.sv
// Directed bench for fast_iret_seq: one task per scenario, each checking itself.
module tb_fast_iret_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        mode64 = 1'b1;
    logic [1:0]  cur_cpl = 2'd0;
    logic [63:0] cur_sp = '0;
    logic        mem_req;
    logic [63:0] mem_addr;
    logic        mem_ack = 1'b0;
    logic [63:0] mem_rdata = '0;
    logic        done, fault;
    logic [63:0] new_ip, new_sp, new_flags, frame_top;
    logic [15:0] new_cs, new_ss;
    logic [1:0]  new_cpl;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    // Memory model state.
    logic [63:0] frame [5];
    logic [63:0] exp_base;
    int          exp_slot;
    int          rd_count;
    int          addr_err;
    int          ack_gap;
    int          gap_cnt;

    always #4 clk = ~clk;

    fast_iret_seq dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode64(mode64),
        .cur_cpl(cur_cpl), .cur_sp(cur_sp), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .done(done), .fault(fault),
        .new_ip(new_ip), .new_cs(new_cs), .new_ss(new_ss), .new_sp(new_sp),
        .new_flags(new_flags), .new_cpl(new_cpl), .frame_top(frame_top)
    );

    // Memory responder: acknowledges after ack_gap idle cycles, checks addresses.
    always @(negedge clk) begin
        if (mem_req && gap_cnt >= ack_gap) begin
            if (rd_count < 5) begin
                if (mem_addr != exp_base + 64'(rd_count * exp_slot)) addr_err++;
                mem_rdata <= frame[rd_count];
            end else begin
                addr_err++;
            end
            mem_ack <= 1'b1;
            rd_count++;
            gap_cnt = 0;
        end else begin
            mem_ack <= 1'b0;
            if (mem_req) gap_cnt++;
        end
    end

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    // Watchdog: a hung run counts as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected fewer than 100000", cycles);
            finish_run();
        end
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] exp_flags(input logic [63:0] f, input logic wide);
        logic [63:0] v;
        v = wide ? f : (f & 64'h0000_0000_FFFF_FFFF);
        v = v & ~(64'h1 << 8) & ~(64'h1 << 10) & ~(64'h3 << 12) & ~(64'h1 << 14)
              & ~(64'h7 << 16);
        return v | (64'h1 << 9);
    endfunction

    // Starts one operation and waits for done or fault; also checks R8 pulse and R10.
    task automatic run_op(input logic wide, input logic [1:0] cpl, input logic [63:0] sp,
                          input int mid_start, output logic got_done, output logic got_fault);
        int n;
        rd_count = 0; addr_err = 0; gap_cnt = 0;
        exp_base = sp; exp_slot = wide ? 8 : 4;
        @(negedge clk);
        mode64 = wide; cur_cpl = cpl; cur_sp = sp; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_done = 1'b0; got_fault = 1'b0;
        n = 0;
        while (!done && !fault && n < 60) begin
            if (mid_start != 0 && n == 2) begin
                start = 1'b1; cur_sp = sp + 64'h1000; mode64 = ~wide;
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        got_done = done; got_fault = fault;
        chk("R10 done/fault exclusive", 64'(done & fault), 64'd0);
        @(negedge clk);
        chk("R8 done one-cycle", 64'(done), 64'd0);
        chk("R2/R7 fault one-cycle", 64'(fault), 64'd0);
    endtask

    task automatic t_reset();
        chk("R1 done in reset", 64'(done), 64'd0);
        chk("R1 fault in reset", 64'(fault), 64'd0);
        chk("R1 mem_req in reset", 64'(mem_req), 64'd0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        chk("R1 done after reset", 64'(done), 64'd0);
        chk("R1 new_ip after reset", new_ip, 64'd0);
        chk("R1 frame_top after reset", frame_top, 64'd0);
        chk("R1 new_flags after reset", new_flags, 64'd0);
        chk("R1 new_cpl/cs/ss after reset", {30'd0, new_cpl, new_cs, new_ss}, 64'd0);
    endtask

    task automatic t_user64();
        logic d, f;
        frame[0] = 64'h0000_7FFF_1234_5678;
        frame[1] = 64'hAAAA_0000_0000_0033;
        frame[2] = 64'hFFFF_FFFF_FFFF_FFFF;
        frame[3] = 64'h0000_7FFF_FFFF_E000;
        frame[4] = 64'h0000_0000_0000_002B;
        ack_gap = 0;
        run_op(1'b1, 2'd0, 64'h0000_0000_0010_0000, 0, d, f);
        chk("R8 done on user64", 64'(d), 64'd1);
        chk("R3 address order 64-bit", 64'(addr_err), 64'd0);
        chk("R3 read count 64-bit", 64'(rd_count), 64'd5);
        chk("R3 new_ip", new_ip, frame[0]);
        chk("R4 new_cs", 64'(new_cs), 64'h33);
        chk("R4 new_cpl level 3", 64'(new_cpl), 64'd3);
        chk("R3 new_sp", new_sp, frame[3]);
        chk("R4 new_ss", 64'(new_ss), 64'h2B);
        chk("R5 flags all-ones", new_flags, exp_flags(frame[2], 1'b1));
        chk("R8 frame_top 64-bit", frame_top, 64'h0000_0000_0010_0028);
    endtask

    task automatic t_kernel64_slow();
        logic d, f;
        frame[0] = 64'hFFFF_8000_0000_0000;
        frame[1] = 64'h0000_0000_0000_0010;
        frame[2] = 64'h0000_0000_0000_0000;
        frame[3] = 64'hFFFF_C900_0000_1F00;
        frame[4] = 64'h0000_0000_0000_0018;
        ack_gap = 2;
        run_op(1'b1, 2'd0, 64'hFFFF_C900_0000_0F00, 0, d, f);
        chk("R7 boundary canonical accepted", 64'(d), 64'd1);
        chk("R3 address order with stalls", 64'(addr_err), 64'd0);
        chk("R4 new_cpl level 0", 64'(new_cpl), 64'd0);
        chk("R5 flags all-zero sets IF", new_flags, 64'h200);
        chk("R3 new_ip kernel", new_ip, frame[0]);
        chk("R8 frame_top kernel", frame_top, 64'hFFFF_C900_0000_0F28);
    endtask

    task automatic t_ret32();
        logic d, f;
        frame[0] = 64'hDEAD_BEEF_0804_8000;
        frame[1] = 64'hDEAD_BEEF_0000_0023;
        frame[2] = 64'hDEAD_BEEF_0007_7702;
        frame[3] = 64'hDEAD_BEEF_FFFF_D000;
        frame[4] = 64'hDEAD_BEEF_0000_002B;
        ack_gap = 1;
        run_op(1'b0, 2'd0, 64'h0000_0000_0020_0000, 0, d, f);
        chk("R6 done on 32-bit", 64'(d), 64'd1);
        chk("R3 address stride 4", 64'(addr_err), 64'd0);
        chk("R6 ip zero-extended", new_ip, 64'h0000_0000_0804_8000);
        chk("R6 sp zero-extended", new_sp, 64'h0000_0000_FFFF_D000);
        chk("R6 flags zero-extended", new_flags, exp_flags(frame[2], 1'b0));
        chk("R4 new_cpl from 32-bit cs", 64'(new_cpl), 64'd3);
        chk("R8 frame_top 32-bit", frame_top, 64'h0000_0000_0020_0014);
    endtask

    task automatic t_noncanon(input logic [63:0] bad_ip);
        logic d, f;
        logic [63:0] old_ip, old_top;
        old_ip = new_ip; old_top = frame_top;
        frame[0] = bad_ip;
        frame[1] = 64'h33; frame[2] = 64'h202; frame[3] = 64'h7000; frame[4] = 64'h2B;
        ack_gap = 0;
        run_op(1'b1, 2'd0, 64'h0000_0000_0030_0000, 0, d, f);
        chk("R7 non-canonical faults", 64'(f), 64'd1);
        chk("R7 no done on non-canonical", 64'(d), 64'd0);
        chk("R7 new_ip unchanged", new_ip, old_ip);
        chk("R7 frame_top unchanged", frame_top, old_top);
    endtask

    task automatic t_priv();
        logic d, f;
        logic [63:0] old_ip, old_top;
        old_ip = new_ip; old_top = frame_top;
        ack_gap = 0;
        run_op(1'b1, 2'd3, 64'h0000_0000_0040_0000, 0, d, f);
        chk("R2 fault at level 3", 64'(f), 64'd1);
        chk("R2 no memory read", 64'(rd_count), 64'd0);
        chk("R2 new_ip unchanged", new_ip, old_ip);
        chk("R2 frame_top unchanged", frame_top, old_top);
    endtask

    task automatic t_busy_start();
        logic d, f;
        frame[0] = 64'h0000_0000_0040_1000;
        frame[1] = 64'h10; frame[2] = 64'h46; frame[3] = 64'h0000_0000_0050_0000;
        frame[4] = 64'h18;
        ack_gap = 1;
        run_op(1'b1, 2'd0, 64'h0000_0000_0060_0000, 1, d, f);
        chk("R9 single completion", 64'(d), 64'd1);
        chk("R9 original base kept", frame_top, 64'h0000_0000_0060_0028);
        chk("R9 addresses unaffected", 64'(addr_err), 64'd0);
        chk("R9 no extra reads", 64'(rd_count), 64'd5);
        repeat (4) @(negedge clk);
        chk("R9 no second done", 64'(done), 64'd0);
        chk("R9 new_ip from first frame", new_ip, frame[0]);
    endtask

    initial begin
        ack_gap = 0; gap_cnt = 0; rd_count = 0; addr_err = 0;
        exp_base = '0; exp_slot = 8;
        for (int i = 0; i < 5; i++) frame[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        t_user64();
        t_kernel64_slow();
        t_ret32();
        t_noncanon(64'h0000_8000_0000_0000);
        t_noncanon(64'hFFFF_7FFF_FFFF_FFFF);
        t_priv();
        t_busy_start();
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule